// File: doc/BRIEF.md
# Byte Serial Transmitter with Control and Status Register

This block sends bytes on a single serial line in asynchronous framing. A host loads one byte at a time into a single-entry holding buffer through a plain register bus. The buffer feeds a ten-bit shift register. Each frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. A programmable prescaler divides the base clock to set the bit rate, and every serial bit spans sixteen prescaler ticks.

An 8-bit control/status register holds two writable fields: the transmit enable and a two-bit rate select. It also reports two read-only flags. One shows that the holding buffer is empty. The other shows that the transmitter is active, meaning a frame is on the line or a byte is waiting. Buffer writes are accepted only while the channel is enabled. Clearing the enable stops the current frame at once, returns the line to the idle level and discards any waiting byte. An interrupt request asks for the next byte while the channel is enabled and the buffer is empty. When a frame ends with a byte waiting, the next frame starts on the next bit boundary.

Top module: `sertx_chan`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x12 (disabled, buffer empty, inactive, rate select 01), `txd` is 1 and `tx_irq` is 0.
- R2: The register bits use LSB-0 numbering. Bit 0 is the enable (read/write), bit 1 is buffer empty (read-only), bit 2 is active (read-only) and bits 5:4 are the rate select (read/write). Bits 7, 6 and 3 always read 0, whatever was written to them.
- R3: Each serial bit lasts exactly 16×D clock cycles. D is 1, 8, 32 or 256 for rate select 00, 01, 10 or 11.
- R4: A frame is a 0 start bit, then data bits 0 to 7, then a 1 stop bit. The line is 1 whenever the active flag is 0.
- R5: A buffer write while enabled clears the empty flag and sets the active flag from the next cycle. One cycle later the byte moves into an idle shifter, the empty flag returns to 1 and the start bit appears on `txd`.
- R6: A buffer write while the enable is 0 has no effect. The empty flag stays 1, the active flag stays 0, and the byte is never transmitted after a later enable.
- R7: A control write with bit 0 clear aborts at once. From the next cycle `txd` is 1, empty is 1, active is 0, and a later re-enable does not resume the frame.
- R8: If the buffer holds a byte when a stop bit ends, the next start bit begins in the very next cycle with no idle gap.
- R9: Once the stop bit ends and the buffer is empty, the active flag reads 0 and `txd` stays 1.
- R10: `tx_irq` is 1 exactly when the enable and the empty flag are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write data |
| buf_we | input | 1 | Write strobe for the transmit buffer low byte |
| buf_wdata | input | DATA_W | Byte to transmit |
| ctl_rdata | output | 8 | Control/status read-back |
| txd | output | 1 | Serial data line, idle high |
| tx_irq | output | 1 | Buffer-empty interrupt request |

## Verification
The bound checker checks several rules on every cycle. The reserved bits always read zero, the interrupt always tracks the enable and empty flags, and the line stays high while inactive. It also checks the one-cycle effect of an accepted buffer write, an ignored buffer write and an aborting control write. Bit durations at all four rates, LSB-first ordering, gapless chaining of two frames and the absence of any resume after an abort span many cycles. Only the bench's directed and seeded random frames show those.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [1:0] {
      RATE_DIV1   = 2'b00,
      RATE_DIV8   = 2'b01,
      RATE_DIV32  = 2'b10,
      RATE_DIV256 = 2'b11
   } rate_sel_e;

   localparam int CTL_EN_BIT    = 0;
   localparam int CTL_EMPTY_BIT = 1;
   localparam int CTL_ACT_BIT   = 2;
   localparam int CTL_SEL_LO    = 4;

   // largest log2 divide among the four rate choices
   function automatic int max_log2(logic [3:0][3:0] v);
      int m;
      m = 0;
      for (int i = 0; i < 4; i++)
         if (int'(v[i]) > m) m = int'(v[i]);
      return m;
   endfunction

endpackage

// File: rtl/sertx_prescale.sv
module sertx_prescale #(
   parameter logic [3:0][3:0] DIV_LOG2 = {4'd8, 4'd5, 4'd3, 4'd0}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam int CNT_W = sertx_pkg::max_log2(DIV_LOG2);

   if (CNT_W == 0) begin : g_nodiv
      assign tick = run;
   end else begin : g_div
      function automatic logic [CNT_W-1:0] term_of(logic [1:0] s);
         logic [CNT_W:0] v;
         v = '0;
         v[DIV_LOG2[s]] = 1'b1;
         return CNT_W'(v - 1'b1);
      endfunction

      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] term;

      assign term = term_of(sel);
      // >= so that a rate change mid-count never overruns the terminal
      assign tick = run && (cnt_q >= term);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (!run)   cnt_q <= '0;
         else if (tick)   cnt_q <= '0;
         else             cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sertx_txbuf.sv
module sertx_txbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              take,
   input  logic              flush,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      full <= 1'b0;
      else if (flush)  full <= 1'b0;
      else if (wr)     full <= 1'b1;
      else if (take)   full <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      data <= '0;
      else if (wr)     data <= wdata;
   end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              tick,
   input  logic              load_req,
   input  logic [DATA_W-1:0] load_data,
   output logic              take,
   output logic              busy,
   output logic              line
);
   localparam int FRAME_BITS = DATA_W + 2;
   localparam int BIT_W      = $clog2(FRAME_BITS);
   localparam int SUB_W      = $clog2(OVS);

   logic [FRAME_BITS-1:0] sh_q;
   logic [BIT_W-1:0]      bit_q;
   logic [SUB_W-1:0]      sub_q;
   logic                  busy_q;
   logic                  boundary;
   logic                  last;

   assign boundary = busy_q && tick && (sub_q == SUB_W'(OVS - 1));
   assign last     = boundary && (bit_q == BIT_W'(FRAME_BITS - 1));
   assign take     = !abort && load_req && (!busy_q || last);
   assign busy     = busy_q;
   assign line     = !busy_q || sh_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sh_q   <= '0;
         bit_q  <= '0;
         sub_q  <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         sh_q   <= '0;
         bit_q  <= '0;
         sub_q  <= '0;
      end else if (take) begin
         busy_q <= 1'b1;
         sh_q   <= {1'b1, load_data, 1'b0};
         bit_q  <= '0;
         sub_q  <= '0;
      end else if (last) begin
         busy_q <= 1'b0;
         sh_q   <= '0;
         bit_q  <= '0;
         sub_q  <= '0;
      end else if (boundary) begin
         sh_q   <= {1'b1, sh_q[FRAME_BITS-1:1]};
         bit_q  <= bit_q + 1'b1;
         sub_q  <= '0;
      end else if (busy_q && tick) begin
         sub_q  <= sub_q + 1'b1;
      end
   end

endmodule

// File: rtl/sertx_chan.sv
module sertx_chan #(
   parameter int              DATA_W   = 8,
   parameter int              OVS      = 16,
   parameter logic [3:0][3:0] DIV_LOG2 = {4'd8, 4'd5, 4'd3, 4'd0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [7:0]        ctl_wdata,
   input  logic              buf_we,
   input  logic [DATA_W-1:0] buf_wdata,
   output logic [7:0]        ctl_rdata,
   output logic              txd,
   output logic              tx_irq
);
   import sertx_pkg::*;

   if (OVS < 2) begin : g_bad_ovs
      $error("sertx_chan: OVS must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("sertx_chan: DATA_W must be at least 1");
   end

   logic              en_q;
   rate_sel_e         sel_q;
   logic              flush;
   logic              wr;
   logic              take;
   logic              full;
   logic              busy;
   logic              tick;
   logic [DATA_W-1:0] held;
   logic              unused_wbits;

   assign unused_wbits = ^{ctl_wdata[7:6], ctl_wdata[3:1]};

   // a control write with the enable clear wins over any buffer write
   assign flush = ctl_we && !ctl_wdata[CTL_EN_BIT];
   assign wr    = buf_we && en_q && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= RATE_DIV8;
      end else if (ctl_we) begin
         en_q  <= ctl_wdata[CTL_EN_BIT];
         sel_q <= rate_sel_e'(ctl_wdata[CTL_SEL_LO+1:CTL_SEL_LO]);
      end
   end

   sertx_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .sel  (sel_q),
      .tick (tick)
   );

   sertx_txbuf #(.DATA_W(DATA_W)) u_buf (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (wr),
      .wdata(buf_wdata),
      .take (take),
      .flush(flush),
      .full (full),
      .data (held)
   );

   sertx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shf (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort    (flush),
      .tick     (tick),
      .load_req (full),
      .load_data(held),
      .take     (take),
      .busy     (busy),
      .line     (txd)
   );

   always_comb begin
      ctl_rdata                              = '0;
      ctl_rdata[CTL_EN_BIT]                  = en_q;
      ctl_rdata[CTL_EMPTY_BIT]               = !full;
      ctl_rdata[CTL_ACT_BIT]                 = busy || full;
      ctl_rdata[CTL_SEL_LO+1:CTL_SEL_LO]     = sel_q;
   end

   assign tx_irq = en_q && !full;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ctl_we,
   input logic [7:0] ctl_wdata,
   input logic       buf_we,
   input logic [7:0] ctl_rdata,
   input logic       txd,
   input logic       tx_irq
);
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[7:6] == 2'b00 && ctl_rdata[3] == 1'b0);

   a_r10_irq_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq == (ctl_rdata[0] && ctl_rdata[1]));

   a_r4_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[2] |-> txd);

   a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !ctl_wdata[0]) |=> (txd && ctl_rdata[1] && !ctl_rdata[2] && !tx_irq));

   a_r6_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && !ctl_rdata[0]) |=> ctl_rdata[1]);

   a_r5_write_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && ctl_rdata[0] && !(ctl_we && !ctl_wdata[0])) |=> (!ctl_rdata[1] && ctl_rdata[2]));

endmodule

bind sertx_chan sertx_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_we   (ctl_we),
   .ctl_wdata(ctl_wdata),
   .buf_we   (buf_we),
   .ctl_rdata(ctl_rdata),
   .txd      (txd),
   .tx_irq   (tx_irq)
);

// File: tb/sertx_chan_tb_top.sv
module sertx_chan_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       buf_we = 1'b0;
   logic [7:0] buf_wdata = '0;
   logic [7:0] ctl_rdata;
   logic       txd;
   logic       tx_irq;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sertx_chan dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we),
      .ctl_wdata(ctl_wdata),
      .buf_we   (buf_we),
      .buf_wdata(buf_wdata),
      .ctl_rdata(ctl_rdata),
      .txd      (txd),
      .tx_irq   (tx_irq)
   );

   function automatic int div_of(logic [1:0] s);
      case (s)
         2'b00:   return 1;
         2'b01:   return 8;
         2'b10:   return 32;
         default: return 256;
      endcase
   endfunction

   function automatic logic [7:0] reg_exp(logic en, logic empty, logic act, logic [1:0] s);
      return {2'b00, s, 1'b0, act, empty, en};
   endfunction

   function automatic logic frame_bit(logic [7:0] d, int k);
      if (k == 0) return 1'b0;
      if (k == 9) return 1'b1;
      return d[k-1];
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ctl_write(logic [7:0] v);
      ctl_wdata = v;
      ctl_we = 1'b1;
      step(1);
      ctl_we = 1'b0;
   endtask

   task automatic buf_write(logic [7:0] v);
      buf_wdata = v;
      buf_we = 1'b1;
      step(1);
      buf_we = 1'b0;
   endtask

   // check the bits of a frame whose start bit began at the current cycle
   task automatic check_bits(logic [7:0] d, int n);
      int pos;
      pos = 0;
      for (int k = 0; k < 10; k++) begin
         step(16*n*k - pos);
         pos = 16*n*k;
         chk("R4 first cycle of bit", txd, frame_bit(d, k));
         step(16*n - 1);
         pos += 16*n - 1;
         chk("R3 last cycle of bit", txd, frame_bit(d, k));
      end
      step(160*n - pos);
   endtask

   task automatic run_frame(logic [7:0] d, logic [1:0] s);
      ctl_write({2'b00, s, 4'b0001});
      buf_write(d);
      chk("R5 buffer taken", ctl_rdata, reg_exp(1'b1, 1'b0, 1'b1, s));
      chk("R10 irq low while full", tx_irq, 1'b0);
      step(1);
      chk("R5 moved to shifter", ctl_rdata, reg_exp(1'b1, 1'b1, 1'b1, s));
      chk("R10 irq high when empty", tx_irq, 1'b1);
      check_bits(d, div_of(s));
      chk("R9 inactive after stop", ctl_rdata, reg_exp(1'b1, 1'b1, 1'b0, s));
      chk("R9 line idle after stop", txd, 1'b1);
   endtask

   initial begin
      int lows;
      logic [7:0] a;
      logic [7:0] b;
      void'($urandom(32'd7321));
      step(3);
      chk("R1 reset register", ctl_rdata, 8'h12);
      chk("R1 reset line", txd, 1'b1);
      chk("R1 reset irq", tx_irq, 1'b0);
      rst_n = 1'b1;
      step(2);
      chk("R1 register after release", ctl_rdata, 8'h12);

      // R6: write while disabled
      buf_write(8'hA5);
      chk("R6 write ignored", ctl_rdata, 8'h12);
      chk("R6 line idle", txd, 1'b1);
      ctl_write(8'h01);
      lows = 0;
      for (int i = 0; i < 60; i++) begin
         step(1);
         if (txd == 1'b0) lows++;
      end
      chk("R6 nothing sent after enable", lows, 0);
      chk("R6 state after enable", ctl_rdata, 8'h03);

      // R2: reserved bits and field placement
      ctl_write(8'hFF);
      chk("R2 readback all ones", ctl_rdata, 8'h33);
      chk("R10 irq enabled and empty", tx_irq, 1'b1);
      ctl_write(8'hC8);
      chk("R2 readback reserved only", ctl_rdata, 8'h02);
      chk("R10 irq when disabled", tx_irq, 1'b0);

      // R3 R4 R5 R9: frames at every rate
      run_frame(8'h01, 2'b00);
      run_frame(8'h80, 2'b00);
      for (int i = 0; i < 4; i++) run_frame(8'($urandom), 2'b00);
      for (int i = 0; i < 2; i++) run_frame(8'($urandom), 2'b01);
      run_frame(8'($urandom), 2'b10);
      run_frame(8'($urandom), 2'b11);

      // R8: back-to-back frames
      a = 8'($urandom);
      b = 8'($urandom);
      ctl_write(8'h01);
      buf_write(a);
      step(1);
      buf_write(b);
      chk("R8 second byte waiting", ctl_rdata, reg_exp(1'b1, 1'b0, 1'b1, 2'b00));
      step(158);
      chk("R8 stop bit of first frame", txd, 1'b1);
      chk("R8 still active", ctl_rdata[2], 1'b1);
      step(1);
      chk("R8 no gap start bit", txd, 1'b0);
      chk("R8 buffer drained", ctl_rdata, reg_exp(1'b1, 1'b1, 1'b1, 2'b00));
      check_bits(b, 1);
      chk("R9 inactive after chain", ctl_rdata, reg_exp(1'b1, 1'b1, 0, 2'b00));

      // R7: abort mid-frame with a byte waiting
      buf_write(8'h00);
      step(1);
      step(40);
      chk("R4 data bit low", txd, 1'b0);
      buf_write(8'hFF);
      chk("R7 byte waiting before abort", ctl_rdata[1], 1'b0);
      ctl_write(8'h00);
      chk("R7 line idle after abort", txd, 1'b1);
      chk("R7 flags after abort", ctl_rdata, 8'h02);
      chk("R7 irq after abort", tx_irq, 1'b0);
      ctl_write(8'h01);
      lows = 0;
      for (int i = 0; i < 400; i++) begin
         step(1);
         if (txd == 1'b0) lows++;
      end
      chk("R7 no resume after re-enable", lows, 0);
      chk("R7 idle after re-enable", ctl_rdata, 8'h03);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule